// File: doc/BRIEF.md
# Adjustable Microframe SOF Timer

This block produces the start-of-microframe timing for a high-speed USB host. It counts clocks of the bit-time clock and raises a one-clock SOF strobe each time a microframe ends. Software sets the microframe length through a small trim field. The field is held in an 8-bit register that is reached through a plain address, data and write-strobe port.

A run input starts and stops the timer. A halted output tells software when it may retune the trim. The trim value is copied into a shadow register when the timer starts, so the active microframe length cannot change while the timer runs. A 14-bit microframe index counts SOF strobes. Its upper bits give the frame number, which advances once every eight microframes.

Top module: `uframe_sof_timer`

## Requirements
- R1: After reset, halted is 1, the SOF strobe is 0, the microframe index is 0 and the trim field holds 0x20.
- R2: The register lives at address ADJ_ADDR (default 1). A read there returns the 6-bit trim in bits 5:0 and 00b in bits 7:6, and writes to bits 7:6 are dropped. Any other address reads 0, and writes to it change nothing.
- R3: A microframe lasts BASE_LEN + trim·2^STEP_SHIFT clocks. With the defaults (59488 and 16 per step) this spans 59488 clocks at trim 0x00 to 60496 clocks at trim 0x3F, and gives 60000 clocks at the reset value.
- R4: The SOF strobe is exactly one clock wide. It appears on the edge where the counter wraps from its terminal count to zero. Successive strobes are one microframe length apart, and the first strobe comes one microframe length after the start edge.
- R5: A write to the trim that arrives while halted is 0 is discarded. Reads always return the current trim.
- R6: When run is 1 on an edge where the timer is halted, halted falls on that same edge. The counter restarts from zero and uses the trim value latched at that edge.
- R7: When run is cleared, the timer finishes the current microframe. Halted rises on the same edge as that microframe's SOF strobe, and no further strobes follow.
- R8: The microframe index increases by one, modulo 2^14, on every SOF strobe and holds otherwise. The frame number output equals index bits 13:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Run request; 1 starts or keeps running, 0 stops at the end of the microframe |
| regAddr | input | ADDR_W | Register address |
| regWe | input | 1 | Write strobe |
| regWrData | input | REG_W | Write data |
| regRdData | output | REG_W | Read data for regAddr (combinational) |
| sofPulse | output | 1 | One-clock start-of-microframe strobe |
| halted | output | 1 | 1 while the timer is stopped |
| uframeIdx | output | IDX_W | Microframe index |
| frameNum | output | IDX_W-3 | Frame number (index without the low three bits) |

## Verification
The assertions check the following on every cycle:
- The trim is frozen while the timer runs.
- Halted falls on a start edge, and stays low until the terminal count during a stop.
- The counter never exceeds the latched length.
- The strobe is a single clock wide.
- The index steps only with a strobe.

Only the bench scenarios can show the exact period arithmetic for every trim value, the latency from start to the first strobe, the alignment of halted with the final strobe, and how the register port handles reserved bits and foreign addresses.

// File: rtl/sof_timer_pkg.sv
package sof_timer_pkg;
  typedef struct packed {
    logic start;    // begin a fresh microframe, latch the trim
    logic advance;  // timer is running, count this clock
  } ctlStrobe_t;
endpackage

// File: rtl/sof_timer_ctl.sv
module sof_timer_ctl
  import sof_timer_pkg::*;
#(
  parameter int TRIM_W     = 6,
  parameter int TRIM_RESET = 32,
  parameter int REG_W      = 8,
  parameter int ADDR_W     = 2,
  parameter int ADJ_ADDR   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              atTerminal,
  output ctlStrobe_t        ctl,
  output logic [TRIM_W-1:0] trimVal,
  output logic [REG_W-1:0]  regRdData,
  output logic              halted
);
  logic active;
  logic addrHit;
  logic unusedHiBits;

  assign addrHit      = (regAddr == ADDR_W'(ADJ_ADDR));
  assign unusedHiBits = ^regWrData[REG_W-1:TRIM_W];
  assign ctl.start    = !active && runEn;
  assign ctl.advance  = active;
  assign halted       = !active;
  assign regRdData    = addrHit ? REG_W'(trimVal) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      trimVal <= TRIM_W'(TRIM_RESET);
    end else begin
      if (ctl.start)
        active <= 1'b1;
      else if (active && atTerminal && !runEn)
        active <= 1'b0;
      if (regWe && addrHit && !active)
        trimVal <= regWrData[TRIM_W-1:0];
    end
  end

  // R5: trim cannot move while the timer runs
  p_trim_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    !halted |=> $stable(trimVal));
  // R6: a run request while halted leaves halted on the next edge
  p_start_clears_halt_r6: assert property (@(posedge clk) disable iff (!rstN)
    (halted && runEn) |=> !halted);
  // R7: stopping waits for the terminal count
  p_stop_waits_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!halted && !atTerminal) |=> !halted);
endmodule

// File: rtl/sof_timer_dp.sv
module sof_timer_dp
  import sof_timer_pkg::*;
#(
  parameter int BASE_LEN   = 59488,
  parameter int STEP_SHIFT = 4,
  parameter int TRIM_W     = 6,
  parameter int CNT_W      = 16,
  parameter int IDX_W      = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [TRIM_W-1:0] trimVal,
  output logic              atTerminal,
  output logic              sofPulse,
  output logic [IDX_W-1:0]  uframeIdx
);
  logic [CNT_W-1:0]  cnt;
  logic [TRIM_W-1:0] shadowTrim;
  logic [CNT_W-1:0]  lastCount;

  assign lastCount  = CNT_W'(BASE_LEN - 1) + (CNT_W'(shadowTrim) << STEP_SHIFT);
  assign atTerminal = (cnt == lastCount);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt        <= '0;
      shadowTrim <= '0;
      sofPulse   <= 1'b0;
      uframeIdx  <= '0;
    end else if (ctl.start) begin
      cnt        <= '0;
      shadowTrim <= trimVal;
      sofPulse   <= 1'b0;
    end else if (ctl.advance) begin
      if (atTerminal) begin
        cnt       <= '0;
        sofPulse  <= 1'b1;
        uframeIdx <= uframeIdx + 1'b1;
      end else begin
        cnt      <= cnt + 1'b1;
        sofPulse <= 1'b0;
      end
    end else begin
      sofPulse <= 1'b0;
    end
  end

  // R3: the running count never passes the latched terminal value
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |-> (cnt <= lastCount));
  // R4: strobe is a single clock wide
  p_sof_width_r4: assert property (@(posedge clk) disable iff (!rstN)
    sofPulse |=> !sofPulse);
  // R8: the index steps by one with each strobe
  p_idx_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    sofPulse |-> (uframeIdx == IDX_W'($past(uframeIdx) + 1'b1)));
  // R8: the index holds between strobes
  p_idx_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !sofPulse |-> $stable(uframeIdx));
endmodule

// File: rtl/uframe_sof_timer.sv
module uframe_sof_timer
  import sof_timer_pkg::*;
#(
  parameter int BASE_LEN   = 59488,
  parameter int STEP_SHIFT = 4,
  parameter int TRIM_W     = 6,
  parameter int TRIM_RESET = 32,
  parameter int REG_W      = 8,
  parameter int ADDR_W     = 2,
  parameter int ADJ_ADDR   = 1,
  parameter int IDX_W      = 14
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               runEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWe,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  output logic               sofPulse,
  output logic               halted,
  output logic [IDX_W-1:0]   uframeIdx,
  output logic [IDX_W-4:0]   frameNum
);
  localparam int UF_PER_FRAME_LOG2 = 3;
  localparam int MAX_LEN = BASE_LEN + (((1 << TRIM_W) - 1) << STEP_SHIFT);
  localparam int CNT_W   = $clog2(MAX_LEN);

  ctlStrobe_t        ctl;
  logic [TRIM_W-1:0] trimVal;
  logic              atTerminal;

  sof_timer_ctl #(
    .TRIM_W(TRIM_W), .TRIM_RESET(TRIM_RESET), .REG_W(REG_W),
    .ADDR_W(ADDR_W), .ADJ_ADDR(ADJ_ADDR)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .runEn(runEn), .regAddr(regAddr),
    .regWe(regWe), .regWrData(regWrData), .atTerminal(atTerminal),
    .ctl(ctl), .trimVal(trimVal), .regRdData(regRdData), .halted(halted)
  );

  sof_timer_dp #(
    .BASE_LEN(BASE_LEN), .STEP_SHIFT(STEP_SHIFT), .TRIM_W(TRIM_W),
    .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .trimVal(trimVal),
    .atTerminal(atTerminal), .sofPulse(sofPulse), .uframeIdx(uframeIdx)
  );

  assign frameNum = uframeIdx[IDX_W-1:UF_PER_FRAME_LOG2];
endmodule

// File: tb/uframe_sof_timer_tb_top.sv
module uframe_sof_timer_tb_top;
  localparam int BL = 8;
  localparam int SS = 1;
  localparam int ADJ = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 1'b0;
  logic [1:0] regAddr = 2'd1;
  logic regWe = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic sofPulse, halted;
  logic [13:0] uframeIdx;
  logic [10:0] frameNum;

  int checks = 0;
  int failures = 0;
  int expIdx = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uframe_sof_timer #(.BASE_LEN(BL), .STEP_SHIFT(SS)) dut_i (
    .clk(clk), .rstN(rstN), .runEn(runEn), .regAddr(regAddr), .regWe(regWe),
    .regWrData(regWrData), .regRdData(regRdData), .sofPulse(sofPulse),
    .halted(halted), .uframeIdx(uframeIdx), .frameNum(frameNum)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    regAddr = 2'(addr); regWrData = 8'(data); regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input int addr, output int v);
    @(negedge clk);
    regAddr = 2'(addr);
    #1 v = int'(regRdData);
  endtask

  task automatic waitSof(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!sofPulse && n < 1000);
  endtask

  // One start/stop cycle at trim t; optional write attempt while running
  task automatic runOne(input int t, input bit tryWrite);
    int len, n, v;
    len = BL + (t << SS);
    @(negedge clk); runEn = 1'b1;
    @(negedge clk);
    chk("R6 halted low after start", int'(halted), 0);
    n = 1;
    while (!sofPulse && n < 1000) begin @(negedge clk); n++; end
    chk("R3/R4 start-to-first-SOF", n, len + 1);
    expIdx++;
    @(negedge clk);
    chk("R4 strobe one clock wide", int'(sofPulse), 0);
    if (tryWrite) begin
      regAddr = 2'(ADJ); regWrData = 8'h3A; regWe = 1'b1;
      @(negedge clk); regWe = 1'b0;
      #1 chk("R5 write while running discarded", int'(regRdData), t);
      n = 2;
    end else n = 1;
    while (!sofPulse && n < 1000) begin @(negedge clk); n++; end
    chk("R3 microframe period", n, len);
    expIdx++;
    runEn = 1'b0;
    waitSof(n);
    chk("R7 final microframe completes", n, len);
    chk("R7 halted with final SOF", int'(halted), 1);
    expIdx++;
    n = 0;
    for (int k = 0; k < 2 * len; k++) begin
      @(negedge clk);
      if (sofPulse || !halted) n++;
    end
    chk("R7 no strobe after halt", n, 0);
    chk("R8 microframe index", int'(uframeIdx), expIdx);
    chk("R8 frame number", int'(frameNum), expIdx >> 3);
    rd(ADJ, v);
    chk("R5 trim after run", v, t);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 halted at reset", int'(halted), 1);
    chk("R1 sof at reset", int'(sofPulse), 0);
    chk("R1 index at reset", int'(uframeIdx), 0);
    rd(ADJ, v);
    chk("R1 trim reset 0x20", v, 32);

    wr(ADJ, 8'hFF);
    rd(ADJ, v);
    chk("R2 reserved bits read zero", v, 8'h3F);
    wr(2, 8'h05);
    rd(2, v);
    chk("R2 foreign address reads zero", v, 0);
    rd(ADJ, v);
    chk("R2 foreign write ignored", v, 8'h3F);

    wr(ADJ, 5);
    runOne(5, 1'b1);
    wr(ADJ, 32);
    runOne(32, 1'b0);

    for (int t = 0; t < 64; t++) begin
      wr(ADJ, 8'hC0 | t);
      rd(ADJ, v);
      chk("R2 trim write while halted", v, t);
      runOne(t, 1'b0);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule